// File: doc/BRIEF.md
# Video DAC Clock Parameter Register Port

This block is the host-facing register port of a video DAC that also contains a programmable clock synthesizer. A byte-wide bus with two register-offset bits reaches four registers. A separate bank input picks which four. With the bank input low, the offsets reach a stub colour-table bank that keeps only its mask and two address registers. With the bank input high, they reach a small clock parameter memory, a control byte and the address pointers that index that memory.

The parameter memory has 24 two-byte entries. Entries 0x00 to 0x0F are video clock settings and 0x10 to 0x17 are memory clock settings. Each entry holds a feedback divider N in its low byte and, in its high byte, a post-divider exponent K and an input divider M. A clock-select byte picks the active video entry and memory entry. Software reaches that byte only through a hidden sequence: it reads the write-pointer register four times, and the next access to that register reads or writes the select byte. The active video entry index is the select field ORed with four external frequency-select pins. The block outputs N, M and K for the active video and memory entries, so that synthesizer logic downstream can use them.

Top module: `dac_clkram_port`

## Requirements
- R1: With `bank_hi`=0, offset 0 is the pixel mask, offset 1 the colour read pointer and offset 2 the colour write pointer; each reads back the last byte written to it. Offset 3 reads 0x00, and writes to it change no clock register and no parameter entry.
- R2: With `bank_hi`=1, offset 0 is the control byte, offset 1 the parameter read pointer, offset 2 the parameter write pointer and offset 3 the parameter data port. Offsets 0, 1 and 2 read back the last byte written to them, with offset 2 subject to R6.
- R3: A write to the data port goes to the entry at the write pointer: the first write after a pointer load stores the low byte, the second stores the high byte, and the write pointer then advances by one. A write to either pointer register sets the shared low/high phase back to the low byte.
- R4: A read of the data port returns the low byte and then the high byte of the entry at the read pointer, using the same low/high phase. The read pointer advances by one after the high byte is read.
- R5: Pointer values above 0x17 address no entry: data reads there return 0x00 and data writes there store nothing. They do not alias onto valid entries.
- R6: After four consecutive reads of offset 2 with `bank_hi`=1, the fifth access to offset 2 reaches the clock-select byte. A read returns it, and a write replaces it and leaves the write pointer unchanged. The sequence then starts over.
- R7: Any bus access other than a read of the `bank_hi`=1 offset 2 clears the hidden-sequence count. This covers accesses in either bank and a write to offset 2 before the count is complete.
- R8: Clock-select bit 7 is a hold flag. When it is 0, the video entry index equals `freq_sel` and the memory entry index is 0. When it is 1, the video index is select bits 3:0 ORed with `freq_sel`, and the memory index is select bits 6:4.
- R9: `vid_n`/`mem_n` carry the low byte of the active entry, `*_k` carry high-byte bits 7:6 and `*_m` carry high-byte bits 4:0. They are registered and follow any change to an entry, to the select byte or to `freq_sel` one clock later.
- R10: After reset, all entries, all registers, the clock-select byte and `rdata` are 0x00, and the hidden-sequence count is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_hi | input | 1 | Bank select: 0 colour stub, 1 clock registers |
| reg_sel | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe, one access per cycle (wins if `rd_en` is also high) |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after the read |
| freq_sel | input | 4 | External video frequency-select pins |
| vid_n | output | 8 | Active video entry N |
| vid_m | output | 5 | Active video entry M |
| vid_k | output | 2 | Active video entry K |
| mem_n | output | 8 | Active memory entry N |
| mem_m | output | 5 | Active memory entry M |
| mem_k | output | 2 | Active memory entry K |

## Verification
The hardest state to reach from the ports is the armed hidden sequence, together with the ways it can break. The stimulus builds runs of pointer reads that are cut short by a control read, by a colour-bank read and by a pointer write. It then checks that only a fifth uninterrupted access returns the select byte. It also checks that a hidden write leaves the write pointer intact. With the select byte loaded through that path, a sweep covers every video index against every `freq_sel` value and checks the ORed entry against a bench copy of the memory filled with arithmetic patterns.

// File: rtl/dac_clk_pkg.sv
package dac_clk_pkg;

  localparam int VID_ENTRIES_D  = 16;
  localparam int MEM_ENTRIES_D  = 8;
  localparam int UNLOCK_READS_D = 4;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RDADDR = 2'd1,
    REG_WRADDR = 2'd2,
    REG_DATA   = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic [7:0] n;
    logic [4:0] m;
    logic [1:0] k;
  } pll_param_t;

endpackage

// File: rtl/dac_unlock_counter.sv
module dac_unlock_counter #(
  parameter int READS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic wa_read,
  output logic armed
);
  localparam int CW = $clog2(READS + 1);
  localparam logic [CW-1:0] FULL = CW'(READS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (acc) begin
      if (wa_read && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      else                          cnt_q <= '0;
    end
  end

  assign armed = (cnt_q == FULL);
endmodule

// File: rtl/dac_active_sel.sv
module dac_active_sel #(
  parameter int VW = 4,
  parameter int MW = 3
) (
  input  logic [7:0]    csel,
  input  logic [VW-1:0] ext_sel,
  output logic [VW-1:0] vidx,
  output logic [MW-1:0] midx
);
  logic hold;
  assign hold = csel[7];

  always_comb begin
    if (hold) begin
      vidx = csel[VW-1:0] | ext_sel;
      midx = csel[4 +: MW];
    end else begin
      vidx = ext_sel;
      midx = '0;
    end
  end
endmodule

// File: rtl/dac_param_ram.sv
module dac_param_ram
  import dac_clk_pkg::*;
#(
  parameter int VID    = 16,
  parameter int MEM    = 8,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic                     whi,
  input  logic [7:0]               wdata,
  input  logic [ADDR_W-1:0]        raddr,
  input  logic                     rhi,
  output logic [7:0]               rbyte,
  input  logic [$clog2(VID)-1:0]   vidx,
  input  logic [$clog2(MEM)-1:0]   midx,
  output pll_param_t               vid_o,
  output pll_param_t               mem_o
);
  localparam int DEPTH = VID + MEM;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

  logic [7:0] lo_q [DEPTH];
  logic [7:0] hi_q [DEPTH];

  logic          w_ok, r_ok;
  logic [IW-1:0] w_ix, r_ix, v_ix, m_ix;

  assign w_ok = (waddr < DEPTH_A);
  assign r_ok = (raddr < DEPTH_A);
  assign w_ix = waddr[IW-1:0];
  assign r_ix = raddr[IW-1:0];
  assign v_ix = IW'(vidx);
  assign m_ix = IW'(VID) + IW'(midx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        lo_q[i] <= 8'h00;
        hi_q[i] <= 8'h00;
      end
    end else if (we && w_ok) begin
      if (whi) hi_q[w_ix] <= wdata;
      else     lo_q[w_ix] <= wdata;
    end
  end

  always_comb begin
    if (!r_ok)    rbyte = 8'h00;
    else if (rhi) rbyte = hi_q[r_ix];
    else          rbyte = lo_q[r_ix];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_o <= '0;
      mem_o <= '0;
    end else begin
      vid_o.n <= lo_q[v_ix];
      vid_o.m <= hi_q[v_ix][4:0];
      vid_o.k <= hi_q[v_ix][7:6];
      mem_o.n <= lo_q[m_ix];
      mem_o.m <= hi_q[m_ix][4:0];
      mem_o.k <= hi_q[m_ix][7:6];
    end
  end
endmodule

// File: rtl/dac_clkram_port.sv
module dac_clkram_port
  import dac_clk_pkg::*;
#(
  parameter int VID_ENTRIES  = VID_ENTRIES_D,
  parameter int MEM_ENTRIES  = MEM_ENTRIES_D,
  parameter int UNLOCK_READS = UNLOCK_READS_D,
  localparam int VW = $clog2(VID_ENTRIES),
  localparam int MW = $clog2(MEM_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_hi,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [VW-1:0] freq_sel,
  output logic [7:0]    vid_n,
  output logic [4:0]    vid_m,
  output logic [1:0]    vid_k,
  output logic [7:0]    mem_n,
  output logic [4:0]    mem_m,
  output logic [1:0]    mem_k
);
  logic acc, is_rd, ck, hit_wa, hit_ra, hit_data, hit_ctrl;
  logic armed, hidden, wa_read;

  logic [7:0] wa_q, ra_q, csel_q, ctrl_q, pmask_q, prd_q, pwr_q, rdata_q;
  logic       tog_q;
  logic [7:0] ram_byte, rd_mux;

  logic [VW-1:0] vidx;
  logic [MW-1:0] midx;
  pll_param_t    vid_p, mem_p;

  assign acc      = wr_en | rd_en;
  assign is_rd    = rd_en & ~wr_en;
  assign ck       = acc & bank_hi;
  assign hit_wa   = ck & (reg_sel == REG_WRADDR);
  assign hit_ra   = ck & (reg_sel == REG_RDADDR);
  assign hit_data = ck & (reg_sel == REG_DATA);
  assign hit_ctrl = ck & (reg_sel == REG_CTRL);
  assign hidden   = hit_wa & armed;
  assign wa_read  = hit_wa & is_rd;

  dac_unlock_counter #(.READS(UNLOCK_READS)) u_unlock (
    .clk(clk), .rst(rst), .acc(acc), .wa_read(wa_read), .armed(armed)
  );

  dac_active_sel #(.VW(VW), .MW(MW)) u_sel (
    .csel(csel_q), .ext_sel(freq_sel), .vidx(vidx), .midx(midx)
  );

  dac_param_ram #(.VID(VID_ENTRIES), .MEM(MEM_ENTRIES), .ADDR_W(8)) u_ram (
    .clk(clk), .rst(rst),
    .we(hit_data & wr_en), .waddr(wa_q), .whi(tog_q), .wdata(wdata),
    .raddr(ra_q), .rhi(tog_q), .rbyte(ram_byte),
    .vidx(vidx), .midx(midx), .vid_o(vid_p), .mem_o(mem_p)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (bank_hi) begin
      case (reg_sel)
        REG_CTRL:   rd_mux = ctrl_q;
        REG_RDADDR: rd_mux = ra_q;
        REG_WRADDR: rd_mux = hidden ? csel_q : wa_q;
        default:    rd_mux = ram_byte;
      endcase
    end else begin
      case (reg_sel)
        2'd0:    rd_mux = pmask_q;
        2'd1:    rd_mux = prd_q;
        2'd2:    rd_mux = pwr_q;
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q    <= '0;
      ra_q    <= '0;
      tog_q   <= 1'b0;
      csel_q  <= '0;
      ctrl_q  <= '0;
      pmask_q <= '0;
      prd_q   <= '0;
      pwr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (hit_wa && wr_en && !hidden) begin
        wa_q  <= wdata;
        tog_q <= 1'b0;
      end else if (hit_ra && wr_en) begin
        ra_q  <= wdata;
        tog_q <= 1'b0;
      end else if (hit_data) begin
        tog_q <= ~tog_q;
        if (tog_q) begin
          if (wr_en) wa_q <= wa_q + 8'd1;
          else       ra_q <= ra_q + 8'd1;
        end
      end
      if (hidden && wr_en) csel_q <= wdata;
      if (hit_ctrl && wr_en) ctrl_q <= wdata;
      if (acc && !bank_hi && wr_en) begin
        case (reg_sel)
          2'd0:    pmask_q <= wdata;
          2'd1:    prd_q   <= wdata;
          2'd2:    pwr_q   <= wdata;
          default: ;
        endcase
      end
      if (is_rd) rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
  assign vid_n = vid_p.n;
  assign vid_m = vid_p.m;
  assign vid_k = vid_p.k;
  assign mem_n = mem_p.n;
  assign mem_m = mem_p.m;
  assign mem_k = mem_p.k;
endmodule

// File: rtl/dac_clkram_port_chk.sv
module dac_clkram_port_chk #(
  parameter int DEPTH = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       bank_hi,
  input logic [1:0] reg_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [7:0] wa_q,
  input logic [7:0] ra_q,
  input logic       tog_q,
  input logic       armed
);
  localparam logic [7:0] LAST = 8'(DEPTH - 1);

  a_r3_wa_advance: assert property (@(posedge clk) disable iff (rst)
    (bank_hi && reg_sel == 2'd3 && wr_en && tog_q) |=> (wa_q == $past(wa_q) + 8'd1));

  a_r3_phase_clear: assert property (@(posedge clk) disable iff (rst)
    (bank_hi && reg_sel == 2'd1 && wr_en) |=> !tog_q);

  a_r5_range_zero: assert property (@(posedge clk) disable iff (rst)
    (bank_hi && reg_sel == 2'd3 && rd_en && !wr_en && ra_q > LAST) |=> (rdata == 8'h00));

  a_r6_hidden_keeps_wa: assert property (@(posedge clk) disable iff (rst)
    (bank_hi && reg_sel == 2'd2 && (wr_en || rd_en) && armed) |=> ($stable(wa_q) && !armed));

  a_r7_count_clear: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !(bank_hi && reg_sel == 2'd2 && rd_en && !wr_en)) |=> !armed);
endmodule

bind dac_clkram_port dac_clkram_port_chk #(.DEPTH(VID_ENTRIES + MEM_ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .bank_hi(bank_hi), .reg_sel(reg_sel), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .wa_q(wa_q), .ra_q(ra_q), .tog_q(tog_q), .armed(armed)
);

// File: tb/dac_clkram_port_tb_top.sv
module dac_clkram_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_hi = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] freq_sel = 4'd0;
  logic [7:0] vid_n, mem_n;
  logic [4:0] vid_m, mem_m;
  logic [1:0] vid_k, mem_k;

  int vectors = 0, errors = 0;
  logic [7:0] lo_m [24];
  logic [7:0] hi_m [24];
  logic [7:0] r;

  always #10 clk = ~clk;

  dac_clkram_port dut_i (
    .clk(clk), .rst(rst), .bank_hi(bank_hi), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .freq_sel(freq_sel),
    .vid_n(vid_n), .vid_m(vid_m), .vid_k(vid_k),
    .mem_n(mem_n), .mem_m(mem_m), .mem_k(mem_k)
  );

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic b, input logic [1:0] a, input logic [7:0] d);
    bank_hi = b; reg_sel = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic b, input logic [1:0] a, output logic [7:0] q);
    bank_hi = b; reg_sel = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic hid_wr(input logic [7:0] d);
    logic [7:0] t;
    bus_rd(1'b1, 2'd0, t);
    for (int i = 0; i < 4; i++) bus_rd(1'b1, 2'd2, t);
    bus_wr(1'b1, 2'd2, d);
  endtask

  task automatic check_out(input string req, input int vi, input int mi);
    chk(req, vid_n, lo_m[vi]);
    chk(req, vid_m, hi_m[vi][4:0]);
    chk(req, vid_k, hi_m[vi][7:6]);
    chk(req, mem_n, lo_m[16 + mi]);
    chk(req, {mem_k, mem_m}, {hi_m[16 + mi][7:6], hi_m[16 + mi][4:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) begin
      lo_m[i] = 8'((i * 29 + 5) & 255);
      hi_m[i] = 8'((i * 53 + 17) & 255);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk("R10 rdata", rdata, 0);
    chk("R10 vid_n", vid_n, 0);
    chk("R10 mem_n", mem_n, 0);
    bus_rd(1'b1, 2'd0, r); chk("R10 ctrl", r, 0);
    bus_rd(1'b1, 2'd2, r); chk("R10 wptr", r, 0);
    for (int i = 0; i < 3; i++) bus_rd(1'b1, 2'd2, r);
    bus_rd(1'b1, 2'd2, r); chk("R10 csel", r, 0);

    // R2: clock bank register readback
    bus_wr(1'b1, 2'd0, 8'h5A); bus_rd(1'b1, 2'd0, r); chk("R2 ctrl", r, 8'h5A);
    bus_wr(1'b1, 2'd1, 8'h33); bus_rd(1'b1, 2'd1, r); chk("R2 rptr", r, 8'h33);

    // R3: fill all entries through auto-advance
    bus_wr(1'b1, 2'd2, 8'h00);
    for (int i = 0; i < 24; i++) begin
      bus_wr(1'b1, 2'd3, lo_m[i]);
      bus_wr(1'b1, 2'd3, hi_m[i]);
    end
    bus_rd(1'b1, 2'd2, r); chk("R3 wptr advance", r, 8'h18);

    // R4: read back all entries
    bus_wr(1'b1, 2'd1, 8'h00);
    for (int i = 0; i < 24; i++) begin
      bus_rd(1'b1, 2'd3, r); chk("R4 low", r, lo_m[i]);
      bus_rd(1'b1, 2'd3, r); chk("R4 high", r, hi_m[i]);
    end
    bus_rd(1'b1, 2'd1, r); chk("R4 rptr advance", r, 8'h18);

    // R5: out of range
    for (int i = 0; i < 4; i++) begin bus_rd(1'b1, 2'd3, r); chk("R5 read zero", r, 0); end
    bus_wr(1'b1, 2'd2, 8'h20);
    bus_wr(1'b1, 2'd3, 8'hEE); bus_wr(1'b1, 2'd3, 8'hDD);
    bus_wr(1'b1, 2'd1, 8'h20);
    bus_rd(1'b1, 2'd3, r); chk("R5 oor low", r, 0);
    bus_wr(1'b1, 2'd1, 8'h00);
    bus_rd(1'b1, 2'd3, r); chk("R5 no alias low", r, lo_m[0]);
    bus_rd(1'b1, 2'd3, r); chk("R5 no alias high", r, hi_m[0]);

    // R3: phase reset by pointer write
    bus_wr(1'b1, 2'd2, 8'h05);
    bus_wr(1'b1, 2'd3, 8'h11);
    bus_wr(1'b1, 2'd2, 8'h05);
    bus_wr(1'b1, 2'd3, 8'h44); bus_wr(1'b1, 2'd3, 8'hC7);
    lo_m[5] = 8'h44; hi_m[5] = 8'hC7;
    bus_wr(1'b1, 2'd1, 8'h05);
    bus_rd(1'b1, 2'd3, r); chk("R3 phase reset low", r, 8'h44);
    bus_rd(1'b1, 2'd3, r); chk("R3 phase reset high", r, 8'hC7);

    // R6: hidden write keeps wptr
    bus_wr(1'b1, 2'd2, 8'h09);
    hid_wr(8'hA6);
    bus_rd(1'b1, 2'd2, r); chk("R6 wptr kept", r, 8'h09);
    for (int i = 0; i < 3; i++) bus_rd(1'b1, 2'd2, r);
    bus_rd(1'b1, 2'd2, r); chk("R6 csel read", r, 8'hA6);
    bus_rd(1'b1, 2'd2, r); chk("R6 restart", r, 8'h09);

    // R7: interrupted sequences
    bus_rd(1'b1, 2'd0, r);
    for (int i = 0; i < 3; i++) bus_rd(1'b1, 2'd2, r);
    bus_rd(1'b1, 2'd0, r);
    for (int i = 0; i < 4; i++) begin bus_rd(1'b1, 2'd2, r); chk("R7 ctrl break", r, 8'h09); end
    bus_rd(1'b1, 2'd2, r); chk("R7 fifth after break", r, 8'hA6);
    for (int i = 0; i < 4; i++) bus_rd(1'b1, 2'd2, r);
    bus_rd(1'b0, 2'd0, r);
    bus_rd(1'b1, 2'd2, r); chk("R7 colour break", r, 8'h09);
    bus_rd(1'b1, 2'd0, r);
    for (int i = 0; i < 2; i++) bus_rd(1'b1, 2'd2, r);
    bus_wr(1'b1, 2'd2, 8'h0C);
    for (int i = 0; i < 4; i++) begin bus_rd(1'b1, 2'd2, r); chk("R7 write break", r, 8'h0C); end
    bus_rd(1'b1, 2'd2, r); chk("R7 fifth after write", r, 8'hA6);

    // R1: colour stub bank
    bus_wr(1'b0, 2'd0, 8'h7E); bus_rd(1'b0, 2'd0, r); chk("R1 mask", r, 8'h7E);
    bus_wr(1'b0, 2'd1, 8'h12); bus_rd(1'b0, 2'd1, r); chk("R1 rptr", r, 8'h12);
    bus_wr(1'b0, 2'd2, 8'h34); bus_rd(1'b0, 2'd2, r); chk("R1 wptr", r, 8'h34);
    bus_wr(1'b1, 2'd1, 8'h05);
    bus_wr(1'b0, 2'd3, 8'hFF); bus_wr(1'b0, 2'd3, 8'hFF);
    bus_rd(1'b0, 2'd3, r); chk("R1 data zero", r, 0);
    bus_rd(1'b1, 2'd2, r); chk("R1 clk wptr intact", r, 8'h0C);
    bus_rd(1'b1, 2'd3, r); chk("R1 entry intact low", r, lo_m[5]);
    bus_rd(1'b1, 2'd3, r); chk("R1 entry intact high", r, hi_m[5]);
    bus_rd(1'b1, 2'd0, r); chk("R1 ctrl intact", r, 8'h5A);

    // R8/R9: hold set, sweep index and pins
    for (int v = 0; v < 16; v++) begin
      hid_wr(8'(8'h80 | ((v & 7) << 4) | v));
      for (int e = 0; e < 16; e++) begin
        freq_sel = 4'(e);
        @(negedge clk); @(negedge clk);
        check_out("R8 hold OR", v | e, v & 7);
      end
    end
    // R8: hold clear ignores fields
    hid_wr(8'h7F);
    for (int e = 0; e < 16; e++) begin
      freq_sel = 4'(e);
      @(negedge clk); @(negedge clk);
      check_out("R8 hold clear", e, 0);
    end
    // R9: output follows an entry rewrite
    freq_sel = 4'd3;
    @(negedge clk); @(negedge clk);
    bus_wr(1'b1, 2'd2, 8'h03);
    bus_wr(1'b1, 2'd3, 8'h9B); bus_wr(1'b1, 2'd3, 8'h4D);
    lo_m[3] = 8'h9B; hi_m[3] = 8'h4D;
    @(negedge clk);
    check_out("R9 follow", 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule